// File: doc/BRIEF.md
# Link-Down Status and Access Gate

This block sits between a register and access port and a serial link controller. It keeps a sticky flag that records that the link has gone down. While the flag is set, every access headed downstream is parked and not passed on. Software clears the flag with a register write. After a secondary bus reset, an optional recovery timer can clear the flag with no write.

The link counts as up only while both `link_up` and `phy_en` are high. A high-to-low change of that combined signal sets the flag, and so does a `sbr_pulse`. Coming up for the first time after reset never sets the flag.

Accesses travel on a valid/ready stream through a holding stage one entry deep:
- An upstream beat is accepted when `acc_in_valid` and `acc_in_ready` are both high in the same cycle.
- `acc_in_ready` is high when the stage is empty, or when its entry leaves downstream in that same cycle.
- An accepted beat appears on the downstream side in the next cycle.
- `acc_out_valid` is held low while the flag is set.
- Once `acc_out_valid` is high, the payload stays unchanged until `acc_out_ready` takes the beat.

Top module: `link_down_gate`

## Requirements
- R1: After reset the flag reads 0, the recovery timer is idle, `acc_out_valid` is 0 and `acc_in_ready` is 1.
- R2: A high-to-low change of the effective link (`link_up & phy_en`) sets the flag on the next clock edge, whether `link_up` or `phy_en` fell. The first rise of the link after reset does not set it.
- R3: A one-cycle `sbr_pulse` sets the flag.
- R4: A write to the status register (offset 0x824) with data bit 0 equal to 0 clears the flag on the edge that takes the write. A write with bit 0 equal to 1 leaves it unchanged.
- R5: A set event (down transition or `sbr_pulse`) in the same cycle as a clear, either from software or from the timer, leaves the flag set.
- R6: While the flag is set, `acc_out_valid` stays 0 and the parked access is held. With the single entry occupied, `acc_in_ready` is 0.
- R7: A parked access is presented on `acc_out_*` in the cycle right after the flag clears, with its write bit, address and data unchanged.
- R8: The control register (offset 0x828) has an enable in bit 31 and a cycle count N in bits 30:0. A `sbr_pulse` with the enable at 1 and N nonzero sets the flag and then clears it N clock edges later. When N is 0 or the enable is 0, no clear happens without software.
- R9: When the flag is clear, an accepted access appears downstream one cycle later. Under back-pressure, `acc_out_valid` and the payload stay stable until taken. A new beat is accepted in the same cycle the held one leaves.
- R10: Status read layout: bit 0 is the flag, bit 1 is the live effective link, bit 2 is the timer busy flag, and the other bits read 0. The control register reads back what was written. Any other offset reads 0.
- R11: A down transition of the link while the recovery timer runs stops the timer, so the flag stays set until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_up | input | 1 | Live link-up status from the link controller |
| phy_en | input | 1 | PHY enable; low forces the link down |
| sbr_pulse | input | 1 | One-cycle secondary bus reset indication |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| acc_in_valid | input | 1 | Upstream access valid |
| acc_in_ready | output | 1 | Upstream access ready |
| acc_in_write | input | 1 | Upstream access is a write |
| acc_in_addr | input | ACC_AW | Upstream access address |
| acc_in_wdata | input | ACC_DW | Upstream access write data |
| acc_out_valid | output | 1 | Downstream access valid |
| acc_out_ready | input | 1 | Downstream access ready |
| acc_out_write | output | 1 | Downstream access is a write |
| acc_out_addr | output | ACC_AW | Downstream access address |
| acc_out_wdata | output | ACC_DW | Downstream access write data |

## Verification
The bench tests these corner cases:
- **Clear and set in the same cycle.** A clear that lands in the same cycle as a link drop must not win. A design that got this wrong would let parked accesses through while the link is down.
- **Recovery timer.** It is run with a nonzero count, with a zero count, with the enable off, and with a link drop partway through. Counting off by one shifts the release edge. Ignoring the zero count or the drop clears the flag on its own when it should not.
- **Parked access.** An access parked while the link is down is released after a clear. A release a cycle late, or a corrupted address, is caught.
- **Back-pressure.** Beats are sent while the downstream side stalls. A design that dropped or duplicated a beat, or let the payload change while waiting, fails the per-cycle comparison against the bench's model.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  // Register offsets within the translation register window
  localparam int STATUS_OFS = 'h824;
  localparam int CTRL_OFS   = 'h828;
  // Status field positions
  localparam int ST_DOWN_BIT = 0;
  localparam int ST_LINK_BIT = 1;
  localparam int ST_BUSY_BIT = 2;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_CTRL   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ldg_down_flag.sv
module ldg_down_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic eff_link,
  input  logic sbr_pulse,
  input  logic sw_clr,
  input  logic auto_clr,
  output logic down,
  output logic fall,
  output logic set_evt
);
  logic link_q;
  logic down_q;

  // link_q starts low, so the first rise is not a down event
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= eff_link;
  end

  assign fall    = link_q & ~eff_link;
  assign set_evt = fall | sbr_pulse;

  // setting outranks every clear source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   down_q <= 1'b0;
    else if (set_evt)             down_q <= 1'b1;
    else if (sw_clr || auto_clr)  down_q <= 1'b0;
  end

  assign down = down_q;
endmodule

// File: rtl/ldg_recovery_timer.sv
module ldg_recovery_timer #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cancel,
  input  logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic             busy
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (start)  cnt_q <= load_val;
    else if (cancel) cnt_q <= '0;
    else if (busy)   cnt_q <= cnt_q - ONE;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == ONE);

  a_r11_cancel_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> !busy);
endmodule

// File: rtl/ldg_access_hold.sv
module ldg_access_hold #(
  parameter int PAY_W = 65
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PAY_W-1:0] out_pay
);
  logic             hold_v;
  logic [PAY_W-1:0] hold_pay;
  logic             pop;
  logic             push;

  assign out_valid = hold_v & ~stall;
  assign pop       = out_valid & out_ready;
  assign in_ready  = ~hold_v | pop;
  assign push      = in_valid & in_ready;
  assign out_pay   = hold_pay;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v   <= 1'b0;
      hold_pay <= '0;
    end else if (push) begin
      hold_v   <= 1'b1;
      hold_pay <= in_pay;
    end else if (pop) begin
      hold_v   <= 1'b0;
    end
  end

  // R6/R9: an entry that did not leave stays put, untouched
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_v && !pop) |=> (hold_v && $stable(hold_pay)));
endmodule

// File: rtl/link_down_gate.sv
module link_down_gate #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int ACC_AW = 32,
  parameter int ACC_DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up,
  input  logic              phy_en,
  input  logic              sbr_pulse,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              acc_in_valid,
  output logic              acc_in_ready,
  input  logic              acc_in_write,
  input  logic [ACC_AW-1:0] acc_in_addr,
  input  logic [ACC_DW-1:0] acc_in_wdata,
  output logic              acc_out_valid,
  input  logic              acc_out_ready,
  output logic              acc_out_write,
  output logic [ACC_AW-1:0] acc_out_addr,
  output logic [ACC_DW-1:0] acc_out_wdata
);
  import ldg_pkg::*;

  localparam int CNT_W = DATA_W - 1;
  localparam int PAY_W = 1 + ACC_AW + ACC_DW;

  logic             eff_link;
  reg_sel_e         sel;
  logic             sw_clr;
  logic             ctrl_en;
  logic [CNT_W-1:0] ctrl_cnt;
  logic             tmr_start;
  logic             tmr_done;
  logic             tmr_busy;
  logic             down_q;
  logic             link_fall;
  logic             set_evt;
  logic [PAY_W-1:0] out_pay;

  assign eff_link = link_up & phy_en;

  always_comb begin
    if (reg_addr == ADDR_W'(STATUS_OFS))    sel = SEL_STATUS;
    else if (reg_addr == ADDR_W'(CTRL_OFS)) sel = SEL_CTRL;
    else                                    sel = SEL_NONE;
  end

  assign sw_clr = reg_wr_en && (sel == SEL_STATUS) && !reg_wdata[ST_DOWN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_cnt <= '0;
    end else if (reg_wr_en && sel == SEL_CTRL) begin
      ctrl_en  <= reg_wdata[DATA_W-1];
      ctrl_cnt <= reg_wdata[CNT_W-1:0];
    end
  end

  assign tmr_start = sbr_pulse & ctrl_en & (ctrl_cnt != '0);

  ldg_down_flag u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .eff_link (eff_link),
    .sbr_pulse(sbr_pulse),
    .sw_clr   (sw_clr),
    .auto_clr (tmr_done),
    .down     (down_q),
    .fall     (link_fall),
    .set_evt  (set_evt)
  );

  ldg_recovery_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .cancel  (link_fall),
    .load_val(ctrl_cnt),
    .done    (tmr_done),
    .busy    (tmr_busy)
  );

  ldg_access_hold #(.PAY_W(PAY_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (down_q),
    .in_valid (acc_in_valid),
    .in_ready (acc_in_ready),
    .in_pay   ({acc_in_write, acc_in_addr, acc_in_wdata}),
    .out_valid(acc_out_valid),
    .out_ready(acc_out_ready),
    .out_pay  (out_pay)
  );

  assign {acc_out_write, acc_out_addr, acc_out_wdata} = out_pay;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        reg_rdata[ST_DOWN_BIT] = down_q;
        reg_rdata[ST_LINK_BIT] = eff_link;
        reg_rdata[ST_BUSY_BIT] = tmr_busy;
      end
      SEL_CTRL: begin
        reg_rdata[DATA_W-1]  = ctrl_en;
        reg_rdata[CNT_W-1:0] = ctrl_cnt;
      end
      default: reg_rdata = '0;
    endcase
  end

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> down_q);
  a_r4_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr && !set_evt) |=> !down_q);
  a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_done && !set_evt) |=> !down_q);
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(down_q) && !acc_in_ready) |-> acc_out_valid);
endmodule

// File: tb/link_down_gate_bench.sv
`timescale 1ns/1ps
module link_down_gate_bench;
  localparam int STATUS = 'h824;
  localparam int CTRL   = 'h828;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0, phy_en = 1'b0, sbr_pulse = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [11:0] reg_addr = 12'(STATUS);
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_in_valid = 1'b0, acc_in_ready, acc_in_write = 1'b0;
  logic [31:0] acc_in_addr = '0, acc_in_wdata = '0;
  logic        acc_out_valid, acc_out_ready = 1'b1, acc_out_write;
  logic [31:0] acc_out_addr, acc_out_wdata;

  always #2 clk = ~clk;

  link_down_gate u_link_down_gate (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .phy_en(phy_en),
    .sbr_pulse(sbr_pulse), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .acc_in_valid(acc_in_valid), .acc_in_ready(acc_in_ready),
    .acc_in_write(acc_in_write), .acc_in_addr(acc_in_addr),
    .acc_in_wdata(acc_in_wdata), .acc_out_valid(acc_out_valid),
    .acc_out_ready(acc_out_ready), .acc_out_write(acc_out_write),
    .acc_out_addr(acc_out_addr), .acc_out_wdata(acc_out_wdata));

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit        m_down = 0, m_link_q = 0, m_en = 0, m_hv = 0, m_hw = 0;
  int        m_timer = 0;
  int        m_cnt = 0;
  bit [31:0] m_ha = 0, m_hd = 0;
  int        q_len = 0;

  function automatic bit m_out_valid();
    return m_hv && !m_down;
  endfunction

  function automatic bit m_in_ready();
    return !m_hv || (m_out_valid() && acc_out_ready);
  endfunction

  function automatic logic [31:0] m_rdata();
    logic [31:0] r = '0;
    if (reg_addr == 12'(STATUS)) begin
      r[0] = m_down; r[1] = link_up & phy_en; r[2] = (m_timer != 0);
    end else if (reg_addr == 12'(CTRL)) begin
      r = {m_en, 31'(m_cnt)};
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_down = 0; m_link_q = 0; m_en = 0; m_cnt = 0; m_timer = 0; m_hv = 0;
    end else begin
      bit eff, fall, setv, clr, done, pop, push;
      eff  = link_up & phy_en;
      fall = m_link_q && !eff;
      setv = fall || sbr_pulse;
      clr  = reg_wr_en && reg_addr == 12'(STATUS) && !reg_wdata[0];
      done = (m_timer == 1);
      pop  = m_out_valid() && acc_out_ready;
      push = acc_in_valid && m_in_ready();
      if (setv) m_down = 1;
      else if (clr || done) m_down = 0;
      if (sbr_pulse && m_en && m_cnt != 0) m_timer = m_cnt;
      else if (fall) m_timer = 0;
      else if (m_timer != 0) m_timer = m_timer - 1;
      if (reg_wr_en && reg_addr == 12'(CTRL)) begin
        m_en = reg_wdata[31]; m_cnt = int'(reg_wdata[30:0]);
      end
      if (push) begin
        m_hv = 1; m_hw = acc_in_write; m_ha = acc_in_addr; m_hd = acc_in_wdata;
      end else if (pop) m_hv = 0;
      m_link_q = eff;
    end
  end

  // per-cycle comparison, away from the clock edges
  always begin
    @(negedge clk);
    #1.5;
    if (rst_n) begin
      chk("R6 acc_out_valid", 64'(acc_out_valid), 64'(m_out_valid()));
      chk("R6 acc_in_ready", 64'(acc_in_ready), 64'(m_in_ready()));
      chk("R10 reg_rdata", 64'(reg_rdata), 64'(m_rdata()));
      if (m_out_valid()) begin
        chk("R7 acc_out payload", {31'b0, acc_out_write, acc_out_addr},
            {31'b0, m_hw, m_ha});
        chk("R7 acc_out wdata", 64'(acc_out_wdata), 64'(m_hd));
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic reg_write(int addr, logic [31:0] data);
    reg_wr_en = 1; reg_addr = 12'(addr); reg_wdata = data;
    tick();
    reg_wr_en = 0; reg_addr = 12'(STATUS);
  endtask

  task automatic sbr();
    sbr_pulse = 1; tick(); sbr_pulse = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1: reset state
    chk("R1 flag after reset", 64'(reg_rdata[0]), 0);
    chk("R1 timer idle", 64'(reg_rdata[2]), 0);
    chk("R1 in_ready", 64'(acc_in_ready), 1);
    chk("R1 out_valid", 64'(acc_out_valid), 0);

    // R2: first link-up does not set the flag
    link_up = 1; phy_en = 1; tick(); tick();
    chk("R2 first rise no set", 64'(reg_rdata[0]), 0);
    chk("R10 live link bit", 64'(reg_rdata[1]), 1);

    // R9: pass-through, one cycle latency
    acc_in_valid = 1; acc_in_addr = 32'h1000_0010; acc_in_wdata = 32'hA5A5_0001;
    acc_in_write = 1; tick(); acc_in_valid = 0;
    chk("R9 passthrough valid", 64'(acc_out_valid), 1);
    chk("R9 passthrough addr", 64'(acc_out_addr), 64'h1000_0010);
    tick();

    // R2: link drop via link_up
    link_up = 0; tick(); link_up = 1;
    chk("R2 drop sets flag", 64'(reg_rdata[0]), 1);
    tick();

    // R6: access parked while down
    acc_in_valid = 1; acc_in_addr = 32'h2000_0044; acc_in_wdata = 32'hDEAD_BEEF;
    acc_in_write = 0; tick(); acc_in_valid = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R6 parked no valid", 64'(acc_out_valid), 0);
      chk("R6 single entry full", 64'(acc_in_ready), 0);
      tick();
    end

    // R4: writing 1 does not clear
    reg_write(STATUS, 32'h1);
    chk("R4 write one keeps flag", 64'(reg_rdata[0]), 1);
    chk("R6 still parked", 64'(acc_out_valid), 0);
    // R4/R7: writing 0 clears, release next cycle with payload intact
    reg_write(STATUS, 32'h0);
    chk("R4 write zero clears", 64'(reg_rdata[0]), 0);
    chk("R7 release valid", 64'(acc_out_valid), 1);
    chk("R7 release addr", 64'(acc_out_addr), 64'h2000_0044);
    chk("R7 release data", 64'(acc_out_wdata), 64'hDEAD_BEEF);
    tick();

    // R2: PHY disable sets flag
    phy_en = 0; tick(); phy_en = 1;
    chk("R2 phy disable sets flag", 64'(reg_rdata[0]), 1);
    reg_write(STATUS, 0); tick();

    // R5: drop and clear in the same cycle
    link_up = 0; reg_wr_en = 1; reg_addr = 12'(STATUS); reg_wdata = 0;
    tick(); reg_wr_en = 0; link_up = 1;
    chk("R5 set beats clear", 64'(reg_rdata[0]), 1);
    tick(); reg_write(STATUS, 0); tick();

    // R3/R8: recovery timer with N = 5
    reg_write(CTRL, {1'b1, 31'd5});
    sbr();
    chk("R3 sbr sets flag", 64'(reg_rdata[0]), 1);
    chk("R10 timer busy", 64'(reg_rdata[2]), 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R8 flag before count ends", 64'(reg_rdata[0]), 1);
    end
    tick();
    chk("R8 auto clear after N", 64'(reg_rdata[0]), 0);
    chk("R8 timer idle after", 64'(reg_rdata[2]), 0);

    // R8: zero count, no auto clear
    reg_write(CTRL, {1'b1, 31'd0});
    sbr();
    repeat (10) tick();
    chk("R8 zero count keeps flag", 64'(reg_rdata[0]), 1);
    reg_write(STATUS, 0);
    // R8: enable off, no auto clear
    reg_write(CTRL, {1'b0, 31'd5});
    sbr();
    repeat (10) tick();
    chk("R8 disabled keeps flag", 64'(reg_rdata[0]), 1);
    reg_write(STATUS, 0);

    // R11: drop during recovery cancels the timer
    reg_write(CTRL, {1'b1, 31'd8});
    sbr(); tick();
    link_up = 0; tick(); link_up = 1;
    repeat (12) tick();
    chk("R11 cancel keeps flag", 64'(reg_rdata[0]), 1);
    chk("R11 timer idle", 64'(reg_rdata[2]), 0);
    reg_write(STATUS, 0); tick();

    // R9: back-pressure
    acc_out_ready = 0;
    acc_in_valid = 1; acc_in_addr = 32'h3000_0000; acc_in_wdata = 32'h1; tick();
    acc_in_addr = 32'h3000_0004; acc_in_wdata = 32'h2;
    for (int i = 0; i < 3; i++) begin
      chk("R9 held addr stable", 64'(acc_out_addr), 64'h3000_0000);
      chk("R9 stalled not ready", 64'(acc_in_ready), 0);
      tick();
    end
    acc_out_ready = 1; tick(); acc_in_valid = 0;
    chk("R9 next beat accepted on pop", 64'(acc_out_addr), 64'h3000_0004);
    tick(); tick();

    // mixed random traffic checked against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      link_up       = (r < 3) ? 1'b0 : 1'b1;
      phy_en        = (r == 97) ? 1'b0 : 1'b1;
      sbr_pulse     = (r == 50 || r == 51);
      acc_in_valid  = $urandom_range(0, 1) == 1;
      acc_in_write  = $urandom_range(0, 1) == 1;
      acc_in_addr   = $urandom;
      acc_in_wdata  = $urandom;
      acc_out_ready = $urandom_range(0, 3) != 0;
      reg_wr_en     = (r >= 80 && r < 92);
      reg_addr      = (r >= 88 && r < 90) ? 12'(CTRL) : 12'(STATUS);
      reg_wdata     = (r >= 88) ? {1'b1, 31'($urandom_range(0, 7))}
                                : 32'($urandom_range(0, 1));
      tick();
    end
    reg_wr_en = 0; sbr_pulse = 0; acc_in_valid = 0; link_up = 1; phy_en = 1;
    tick(); tick();

    finished = 1;
    summary();
    $finish;
  end
endmodule